// File: doc/BRIEF.md
# Limit-Compare Alarm Status Unit

This block checks every incoming monitor sample against limits that the host programs, and it gathers the results in a 16-bit sticky alarm word. It takes six unsigned 8-bit supply-rail samples, one 9-bit signed die-temperature sample in half-degree steps, two fan low-speed flags and one chassis-open flag. Each input has its own valid strobe. A rail alarm fires when its sample falls outside a programmable low/high window. The temperature alarm uses a high threshold with a separate release threshold, so the state does not chatter around a single limit.

The host writes limits through a small register write port. It reads the alarm word from `reg_rdata`, and pulsing `reg_re` clears the word. A bit that is hit again in the same cycle as the clear survives, so no event is lost. Only ten bit positions are used, and all the others are held at zero.

Top module: `lim_alarm_top`

## Requirements
- R1: After reset, all limits, the alarm word and the temperature state are zero. A rail sample of 0 then raises no alarm, and a rail sample of 1 raises that rail's alarm.
- R2: A valid rail sample raises its alarm when it is below that rail's low limit or above its high limit. A sample equal to either limit raises nothing.
- R3: Rail channels 0 to 3 map to alarm bits 0 to 3. Channel 4 maps to bit 8 and channel 5 to bit 9.
- R4: Temperature limits are signed whole degrees. The sample is signed half degrees. The temperature state goes active when a valid sample is greater than twice the high limit, and the alarm bit is bit 4.
- R5: The temperature state stays active until a valid sample is less than twice the release limit. While the state is active, bit 4 is set again every cycle, so a read does not end the condition.
- R6: A valid fan 0 low-speed flag sets bit 6, fan 1 sets bit 7, and a valid chassis-open flag sets bit 12.
- R7: A sample or flag whose valid strobe is low has no effect.
- R8: Alarm bits stay set until read. Later in-range samples do not clear them.
- R9: `reg_rdata` shows the alarm word in the same cycle. A cycle with `reg_re` high clears the word at the next clock edge, except for bits whose condition is present in that same cycle.
- R10: Bits 5, 10, 11, 13, 14 and 15 always read as zero.
- R11: Register writes use a 5-bit address, written with `reg_we` high. Rail channel i takes its high limit at address i and its low limit at address 8+i. The temperature high limit is at address 16 and the release limit at address 17. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| volt_sample | input | 48 | Six 8-bit rail samples, channel i in bits [8i+7:8i] |
| volt_valid | input | 6 | Per-channel sample strobe |
| temp_sample | input | 9 | Signed temperature, 0.5 degree units |
| temp_valid | input | 1 | Temperature sample strobe |
| fan_slow | input | 2 | Fan low-speed flags |
| fan_valid | input | 2 | Fan flag strobes |
| chassis_open | input | 1 | Chassis-open flag |
| chassis_valid | input | 1 | Chassis flag strobe |
| reg_we | input | 1 | Limit write enable |
| reg_addr | input | 5 | Limit register address |
| reg_wdata | input | 8 | Limit write data |
| reg_re | input | 1 | Read strobe, clears the alarm word |
| reg_rdata | output | 16 | Alarm word |

## Verification
A corrupted limit register shows up at the ports on the first sample that lands between the true limit and the corrupted one. The alarm bit appears one edge after that sample strobe. A stale or flipped temperature state shows up as bit 4 reappearing, or failing to reappear, at the edge that clears the word after a sample two edges earlier. The sweeps drive every sample value on each channel, and every temperature value both upward and downward, so any wrong threshold or wrong state appears within one full sweep.

// File: rtl/lim_alarm_pkg.sv
package lim_alarm_pkg;
    localparam int WORD_W      = 16;
    localparam int TEMP_BIT    = 4;
    localparam int FAN_BIT0    = 6;
    localparam int CHASSIS_BIT = 12;
    localparam int VLO_BASE    = 8;
    localparam int THI_ADDR    = 16;
    localparam int THYS_ADDR   = 17;

    // alarm bit for a rail channel: first four contiguous, rest skip up
    function automatic int volt_bit(input int ch);
        return (ch < 4) ? ch : ch + 4;
    endfunction

    function automatic logic [WORD_W-1:0] used_mask(input int n_volt, input int n_fan);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < n_volt; i++) m[volt_bit(i)] = 1'b1;
        for (int k = 0; k < n_fan; k++) m[FAN_BIT0 + k] = 1'b1;
        m[TEMP_BIT]    = 1'b1;
        m[CHASSIS_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/lim_volt_chan.sv
module lim_volt_chan #(
    parameter int VW      = 8,
    parameter int AW      = 5,
    parameter int HI_ADDR = 0,
    parameter int LO_ADDR = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [VW-1:0] wdata,
    input  logic [VW-1:0] sample,
    input  logic          valid,
    output logic          trip
);
    typedef struct packed {
        logic [VW-1:0] hi;
        logic [VW-1:0] lo;
    } lim_t;

    lim_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && addr == AW'(HI_ADDR)) st_d.hi = wdata;
        if (we && addr == AW'(LO_ADDR)) st_d.lo = wdata;
        trip = valid && ((sample < st_q.lo) || (sample > st_q.hi));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_VLIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (addr == AW'(HI_ADDR) || addr == AW'(LO_ADDR))) |=> $stable(st_q)); // R11
endmodule

// File: rtl/lim_temp_hyst.sv
module lim_temp_hyst #(
    parameter int TW        = 9,
    parameter int AW        = 5,
    parameter int HI_ADDR   = 16,
    parameter int HYS_ADDR  = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [TW-2:0] wdata,
    input  logic [TW-1:0] sample,
    input  logic          valid,
    output logic          active
);
    typedef struct packed {
        logic [TW-2:0] hi;
        logic [TW-2:0] hys;
        logic          act;
    } th_t;

    th_t  st_d, st_q;
    logic above, below;

    always_comb begin
        // limits are whole degrees; one left shift aligns them to half-degree samples
        above = $signed(sample) > $signed({st_q.hi, 1'b0});
        below = $signed(sample) < $signed({st_q.hys, 1'b0});
        st_d  = st_q;
        if (we && addr == AW'(HI_ADDR))  st_d.hi  = wdata;
        if (we && addr == AW'(HYS_ADDR)) st_d.hys = wdata;
        if (valid) begin
            if (above)      st_d.act = 1'b1;
            else if (below) st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

    AST_TEMP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && above) |=> active); // R4
    AST_TEMP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && below && !above) |=> !active); // R5
    AST_TEMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || (!above && !below)) |=> $stable(active)); // R5
endmodule

// File: rtl/lim_alarm_word.sv
module lim_alarm_word #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] bits;
    } aw_t;

    aw_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.bits = '0;
        st_d.bits = (st_d.bits | set_vec) & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.bits;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((word & $past(word)) == $past(word))); // R8
    AST_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((word & $past(set_vec & MASK)) == $past(set_vec & MASK))); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((word & ~$past(set_vec)) == '0)); // R9
endmodule

// File: rtl/lim_alarm_top.sv
module lim_alarm_top
    import lim_alarm_pkg::*;
#(
    parameter int NUM_VOLT = 6,
    parameter int NUM_FAN  = 2,
    parameter int VW       = 8,
    parameter int TW       = 9,
    parameter int AW       = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_VOLT*VW-1:0] volt_sample,
    input  logic [NUM_VOLT-1:0]    volt_valid,
    input  logic [TW-1:0]          temp_sample,
    input  logic                   temp_valid,
    input  logic [NUM_FAN-1:0]     fan_slow,
    input  logic [NUM_FAN-1:0]     fan_valid,
    input  logic                   chassis_open,
    input  logic                   chassis_valid,
    input  logic                   reg_we,
    input  logic [AW-1:0]          reg_addr,
    input  logic [VW-1:0]          reg_wdata,
    input  logic                   reg_re,
    output logic [WORD_W-1:0]      reg_rdata
);
    localparam logic [WORD_W-1:0] MASK = used_mask(NUM_VOLT, NUM_FAN);

    logic [NUM_VOLT-1:0] volt_trip;
    logic                temp_active;
    logic [WORD_W-1:0]   set_vec;

    for (genvar i = 0; i < NUM_VOLT; i++) begin : g_rail
        lim_volt_chan #(
            .VW(VW), .AW(AW), .HI_ADDR(i), .LO_ADDR(VLO_BASE + i)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
            .wdata(reg_wdata), .sample(volt_sample[i*VW +: VW]),
            .valid(volt_valid[i]), .trip(volt_trip[i])
        );
    end

    lim_temp_hyst #(
        .TW(TW), .AW(AW), .HI_ADDR(THI_ADDR), .HYS_ADDR(THYS_ADDR)
    ) u_temp (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata[TW-2:0]), .sample(temp_sample),
        .valid(temp_valid), .active(temp_active)
    );

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_VOLT; i++) set_vec[volt_bit(i)] = volt_trip[i];
        for (int k = 0; k < NUM_FAN; k++)  set_vec[FAN_BIT0 + k] = fan_valid[k] && fan_slow[k];
        set_vec[TEMP_BIT]    = temp_active;
        set_vec[CHASSIS_BIT] = chassis_valid && chassis_open;
    end

    lim_alarm_word #(.W(WORD_W), .MASK(MASK)) u_word (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(reg_re), .word(reg_rdata)
    );

    AST_QUIET_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && volt_valid == '0 && fan_valid == '0 && !chassis_valid && !temp_active)
        |=> (reg_rdata == '0)); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[5] == 1'b0) && (reg_rdata[15:13] == '0) && (reg_rdata[11:10] == '0)); // R10
endmodule

// File: tb/lim_alarm_top_bench.sv
module lim_alarm_top_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] volt_sample = '0;
    logic [5:0]  volt_valid = '0;
    logic [8:0]  temp_sample = '0;
    logic        temp_valid = 1'b0;
    logic [1:0]  fan_slow = '0;
    logic [1:0]  fan_valid = '0;
    logic        chassis_open = 1'b0;
    logic        chassis_valid = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_re = 1'b0;
    logic [15:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    lim_alarm_top u_lim_alarm_top (
        .clk(clk), .rst_n(rst_n), .volt_sample(volt_sample), .volt_valid(volt_valid),
        .temp_sample(temp_sample), .temp_valid(temp_valid), .fan_slow(fan_slow),
        .fan_valid(fan_valid), .chassis_open(chassis_open), .chassis_valid(chassis_valid),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    function automatic int bpos(input int ch);
        return (ch < 4) ? ch : ch + 4;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_clear();
        reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic vsamp(input int ch, input int v);
        volt_sample[ch*8 +: 8] = 8'(v);
        volt_valid[ch] = 1'b1;
        @(negedge clk);
        volt_valid[ch] = 1'b0;
    endtask

    task automatic set_all_limits(input int lo_base, input int lo_step, input int hi_base, input int hi_step);
        for (int c = 0; c < 6; c++) begin
            wr(c, hi_base + c*hi_step);
            wr(8 + c, lo_base + c*lo_step);
        end
    endtask

    task automatic volt_sweep(input int lo_base, input int lo_step, input int hi_base, input int hi_step);
        set_all_limits(lo_base, lo_step, hi_base, hi_step);
        for (int c = 0; c < 6; c++) begin
            for (int v = 0; v < 256; v++) begin
                logic [15:0] e;
                int lo, hi;
                lo = lo_base + c*lo_step;
                hi = hi_base + c*hi_step;
                e = '0;
                if (v < lo || v > hi) e[bpos(c)] = 1'b1;
                vsamp(c, v);
                chk("R2/R3 rail window", reg_rdata, e);
                rd_clear();
                chk("R9 read clears", reg_rdata, 16'h0);
            end
        end
    endtask

    task automatic temp_step(input int s, input int hi, input int hy, inout bit act);
        if (s > 2*hi) act = 1'b1;
        else if (s < 2*hy) act = 1'b0;
        temp_sample = 9'(s);
        temp_valid = 1'b1;
        @(negedge clk);
        temp_valid = 1'b0;
        @(negedge clk);
        rd_clear();
        chk("R4/R5 temperature state", reg_rdata, act ? 16'h0010 : 16'h0000);
    endtask

    task automatic temp_sweep(input int hi, input int hy);
        bit act;
        act = 1'b0;
        wr(16, hi);
        wr(17, hy);
        for (int s = -256; s < 256; s++) temp_step(s, hi, hy, act);
        for (int s = 255; s >= -256; s--) temp_step(s, hi, hy, act);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 word zero after reset", reg_rdata, 16'h0);
        vsamp(0, 0);
        chk("R1 zero limits pass zero sample", reg_rdata, 16'h0);
        vsamp(0, 1);
        chk("R1 zero high limit trips on one", reg_rdata, 16'h0001);
        rd_clear();
        temp_sample = 9'd1; temp_valid = 1'b1;
        @(negedge clk); temp_valid = 1'b0;
        @(negedge clk);
        chk("R1 zero temp limit, half degree trips", reg_rdata, 16'h0010);
        temp_sample = 9'h1FF; temp_valid = 1'b1;   // -1 half degree, below release 0
        @(negedge clk); temp_valid = 1'b0;
        @(negedge clk);
        rd_clear();
        chk("R1 temp state releases", reg_rdata, 16'h0);

        // R2/R3 sweeps
        volt_sweep(40, 10, 192, 5);
        volt_sweep(192, 0, 192, 0);

        // R7: no valid, no effect
        set_all_limits(100, 0, 150, 0);
        volt_sample = '0;
        fan_slow = 2'b11; chassis_open = 1'b1;
        temp_sample = 9'd200;
        repeat (3) @(negedge clk);
        chk("R7 flags without strobe ignored", reg_rdata, 16'h0);

        // R6: fan and chassis positions
        fan_valid = 2'b01; @(negedge clk); fan_valid = 2'b00;
        chk("R6 fan0 bit 6", reg_rdata, 16'h0040);
        rd_clear();
        fan_valid = 2'b10; @(negedge clk); fan_valid = 2'b00;
        chk("R6 fan1 bit 7", reg_rdata, 16'h0080);
        rd_clear();
        chassis_valid = 1'b1; @(negedge clk); chassis_valid = 1'b0;
        chk("R6 chassis bit 12", reg_rdata, 16'h1000);
        rd_clear();

        // R9: same-cycle set survives the clear
        fan_valid = 2'b01; @(negedge clk);
        reg_re = 1'b1; @(negedge clk); reg_re = 1'b0; fan_valid = 2'b00;
        chk("R9 set during read survives", reg_rdata, 16'h0040);
        rd_clear();
        chk("R9 later read clears", reg_rdata, 16'h0);
        fan_slow = '0; chassis_open = 1'b0;

        // R8: sticky across in-range samples
        vsamp(0, 99);
        vsamp(0, 120);
        vsamp(5, 120);
        repeat (2) @(negedge clk);
        chk("R8 sticky after in-range samples", reg_rdata, 16'h0001);
        rd_clear();

        // R11: unmapped addresses and strobe-less writes
        wr(6, 0); wr(7, 0); wr(14, 0); wr(18, 0); wr(31, 0);
        reg_addr = 5'd8; reg_wdata = 8'd0; @(negedge clk);
        vsamp(0, 120);
        vsamp(0, 100);
        vsamp(0, 150);
        chk("R11 limits kept after ignored writes", reg_rdata, 16'h0);
        vsamp(0, 151);
        chk("R11 high limit still 150", reg_rdata, 16'h0001);
        rd_clear();

        // R10: reserved bits with every source firing
        fan_slow = 2'b11; fan_valid = 2'b11; chassis_open = 1'b1; chassis_valid = 1'b1;
        volt_sample = '0; volt_valid = 6'h3F;
        temp_sample = 9'd255; temp_valid = 1'b1;
        @(negedge clk);
        fan_valid = '0; chassis_valid = 1'b0; volt_valid = '0; temp_valid = 1'b0;
        @(negedge clk);
        chk("R10 only defined bits set", reg_rdata, 16'h13DF);
        rd_clear();

        // R5: read does not reset the temperature condition
        chk("R5 bit 4 returns after read", reg_rdata, 16'h0010);
        rd_clear();
        chk("R5 bit 4 still returns", reg_rdata, 16'h0010);

        // R4/R5 sweeps, positive and negative thresholds
        temp_sweep(20, 10);
        temp_sweep(-5, -20);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule